// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block sits between a queue of 32-bit command words and the pins of an 8-bit NAND flash device. Each accepted word becomes either a single latch cycle (an opcode with CLE high, or an address byte with ALE high) or a data burst of one or more write-strobe or read-strobe cycles. Write bytes are pulled from a byte stream fed by a DMA engine; read bytes are sampled from the I/O lines and pushed out on a byte stream toward that engine.

A word may ask the sequencer to wait for the ready/busy line before the word counts as finished, may mark the end of an operation, and may ask for an interrupt. Completion and error events land in a 13-bit event status register that software clears by writing ones. Strobe low and high times are fixed clock counts set by parameters.

Command word fields: bits 17:16 cycle type (0 address, 1 command, 2 data write, 3 data read), bit 19 wait for ready, bit 18 end of operation, bit 13 interrupt request, bits 7:0 the opcode or address byte, and for data words bits 11:0 the byte count minus one.

Top module: `nand_cycle_seq`

## Requirements
- R1: A word of type 1 (command) or 0 (address) produces exactly one write-strobe pulse with bits 7:0 on the I/O lines and the output drive enable high; CLE is high for type 1, ALE for type 0, and the latch line stays high for the whole pulse. CLE and ALE are never high together.
- R2: A word of type 2 (data write) with bits 11:0 equal to N-1 produces N write-strobe pulses carrying N bytes taken in order from the transmit stream, with CLE and ALE low.
- R3: A word of type 3 (data read) with bits 11:0 equal to N-1 produces N read-strobe pulses; the I/O lines are sampled in the last low cycle of each pulse and the byte appears on the receive stream for one cycle right after the strobe rises, in pulse order.
- R4: Each strobe stays low for exactly T_LOW cycles and high for at least T_HIGH cycles before the next pulse; the write and read strobes are never low at the same time.
- R5: When bit 19 is set, the word does not finish, and sets no status bit, until the ready/busy input reads 1.
- R6: Status bit 9 (command done) is set when a word with bit 18 set finishes; a word with bit 18 clear does not set it.
- R7: Status bit 6 is set when a data write word finishes and status bit 7 when a data read word finishes.
- R8: A data word whose byte count (bits 11:0 plus one) differs from the DMA byte count input sets status bit 11 (command error), drives no strobe and is dropped.
- R9: A clear strobe clears exactly the status bits whose mask bit is 1 and leaves the others.
- R10: The interrupt output is high exactly when some status bit is set that was raised by a word with bit 13 set.
- R11: After reset the status is zero, the interrupt is low, both strobes, CLE and ALE are inactive and the block is ready for a word.
- R12: A new word is accepted only while no word is in progress, and no strobe is low while the block is ready for a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_valid_i | input | 1 | Command word offered |
| entry_data_i | input | 32 | Command word |
| entry_ready_o | output | 1 | Word accepted when high with valid |
| dma_count_i | input | 13 | Byte count programmed for the DMA transfer |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmit byte taken |
| rx_valid_o | output | 1 | Received byte valid (one cycle) |
| rx_data_o | output | 8 | Received byte |
| clr_valid_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 13 | Bits to clear |
| status_o | output | 13 | Event status register |
| irq_o | output | 1 | Interrupt request |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | I/O lines out |
| io_oe_o | output | 1 | I/O output drive enable |
| io_i | input | 8 | I/O lines in |
| rb_i | input | 1 | Ready/busy, 1 = ready |

## Verification
The checks assume the word stream uses only the four defined cycle types and that the transmit stream eventually offers a byte whenever a write burst needs one; the stimulus always holds a transmit byte ready and keeps ready/busy at 1 except in the directed wait test. They also assume the clear mask is driven only while the sequencer is idle, which the stimulus does by clearing between words. Random words mix all four types, burst lengths of 1 to 16, random flags and occasional wrong DMA counts, so every status bit the block owns is raised both with and without an interrupt request.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int LEN_W  = 12;
  localparam int STAT_W = 13;

  localparam int B_WAIT = 19;
  localparam int B_LAST = 18;
  localparam int B_IRQ  = 13;

  localparam int S_TX_DONE  = 6;
  localparam int S_RX_DONE  = 7;
  localparam int S_CMD_DONE = 9;
  localparam int S_CMD_ERR  = 11;

  typedef enum logic [1:0] {
    CT_ADDR = 2'd0,
    CT_CMD  = 2'd1,
    CT_WR   = 2'd2,
    CT_RD   = 2'd3
  } cyc_type_e;

  typedef struct packed {
    cyc_type_e        ctype;
    logic             wait_rdy;
    logic             last;
    logic             irq_en;
    logic [LEN_W-1:0] len;
  } entry_t;

  function automatic entry_t decode_entry(logic [31:0] w);
    entry_t e;
    e.ctype    = cyc_type_e'(w[17:16]);
    e.wait_rdy = w[B_WAIT];
    e.last     = w[B_LAST];
    e.irq_en   = w[B_IRQ];
    e.len      = w[LEN_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic low_o,
  output logic sample_o,
  output logic done_o
);
  localparam int CMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= CW'(T_LOW - 1);
        end
        PH_LOW: if (cnt_q == '0) begin
          ph_q  <= PH_HIGH;
          cnt_q <= CW'(T_HIGH - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_HIGH: if (cnt_q == '0) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign low_o    = (ph_q == PH_LOW);
  assign sample_o = low_o && (cnt_q == '0);
  assign done_o   = (ph_q == PH_HIGH) && (cnt_q == '0);
endmodule

// File: rtl/nseq_status.sv
module nseq_status #(
  parameter int              W    = 13,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] arm_i,
  input  logic         clr_valid_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] armed;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic st_q, arm_q;
      logic clr;
      assign clr = clr_valid_i && clr_mask_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_q  <= 1'b0;
          arm_q <= 1'b0;
        end else begin
          // a new event in the same cycle wins over the clear
          st_q  <= (st_q && !clr) || set_i[i];
          arm_q <= (arm_q && !clr) || (set_i[i] && arm_i[i]);
        end
      end
      assign status_o[i] = st_q;
      assign armed[i]    = arm_q;
    end else begin : g_tie
      assign status_o[i] = 1'b0;
      assign armed[i]    = 1'b0;
    end
  end

  assign irq_o = |(status_o & armed);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nseq_pkg::*;
#(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_valid_i,
  input  logic [31:0]       entry_data_i,
  output logic              entry_ready_o,
  input  logic [LEN_W:0]    dma_count_i,
  input  logic              tx_valid_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [7:0]        rx_data_o,
  input  logic              clr_valid_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  input  logic [7:0]        io_i,
  input  logic              rb_i
);
  localparam logic [STAT_W-1:0] IMPL_BITS =
    STAT_W'((1 << S_TX_DONE) | (1 << S_RX_DONE) | (1 << S_CMD_DONE) | (1 << S_CMD_ERR));

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_PULSE, ST_WAIT, ST_FIN, ST_ERR} state_e;

  state_e           state_q, state_d;
  entry_t           ent_q, ent_in;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [7:0]       byte_q, byte_d;
  logic             is_data, len_bad;
  logic             stb_start, stb_low, stb_sample, stb_done;
  logic [STAT_W-1:0] set_vec, arm_vec;

  assign ent_in  = decode_entry(entry_data_i);
  assign is_data = (ent_in.ctype == CT_WR) || (ent_in.ctype == CT_RD);
  assign len_bad = is_data && ((LEN_W+1)'(ent_in.len) + 1'b1 != dma_count_i);

  always_comb begin
    state_d       = state_q;
    rem_d         = rem_q;
    byte_d        = byte_q;
    stb_start     = 1'b0;
    entry_ready_o = 1'b0;
    tx_ready_o    = 1'b0;
    set_vec       = '0;
    unique case (state_q)
      ST_IDLE: begin
        entry_ready_o = 1'b1;
        if (entry_valid_i) begin
          state_d = len_bad ? ST_ERR : ST_LOAD;
          rem_d   = is_data ? ent_in.len : '0;
          byte_d  = entry_data_i[7:0];
        end
      end
      ST_LOAD: begin
        if (ent_q.ctype == CT_WR) begin
          tx_ready_o = 1'b1;
          if (tx_valid_i) begin
            byte_d    = tx_data_i;
            stb_start = 1'b1;
            state_d   = ST_PULSE;
          end
        end else begin
          stb_start = 1'b1;
          state_d   = ST_PULSE;
        end
      end
      ST_PULSE: if (stb_done) begin
        if (rem_q == '0) state_d = ent_q.wait_rdy ? ST_WAIT : ST_FIN;
        else begin
          rem_d   = rem_q - 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_WAIT: if (rb_i) state_d = ST_FIN;
      ST_FIN: begin
        set_vec[S_CMD_DONE] = ent_q.last;
        set_vec[S_TX_DONE]  = (ent_q.ctype == CT_WR);
        set_vec[S_RX_DONE]  = (ent_q.ctype == CT_RD);
        state_d = ST_IDLE;
      end
      ST_ERR: begin
        set_vec[S_CMD_ERR] = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign arm_vec = ent_q.irq_en ? set_vec : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ent_q      <= '0;
      rem_q      <= '0;
      byte_q     <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      state_q    <= state_d;
      rem_q      <= rem_d;
      byte_q     <= byte_d;
      if (state_q == ST_IDLE && entry_valid_i) ent_q <= ent_in;
      rx_valid_o <= stb_sample && (ent_q.ctype == CT_RD);
      if (stb_sample) rx_data_o <= io_i;
    end
  end

  nseq_strobe #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (stb_start),
    .low_o    (stb_low),
    .sample_o (stb_sample),
    .done_o   (stb_done)
  );

  nseq_status #(.W(STAT_W), .IMPL(IMPL_BITS)) i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_vec),
    .arm_i       (arm_vec),
    .clr_valid_i (clr_valid_i),
    .clr_mask_i  (clr_mask_i),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

  logic on_bus;
  assign on_bus  = (state_q == ST_LOAD) || (state_q == ST_PULSE);
  assign cle_o   = on_bus && (ent_q.ctype == CT_CMD);
  assign ale_o   = on_bus && (ent_q.ctype == CT_ADDR);
  assign io_oe_o = on_bus && (ent_q.ctype != CT_RD);
  assign io_o    = byte_q;
  assign we_no   = !(stb_low && (ent_q.ctype != CT_RD));
  assign re_no   = !(stb_low && (ent_q.ctype == CT_RD));
endmodule

// File: rtl/nseq_checker.sv
module nseq_checker #(
  parameter int T_LOW = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        entry_ready_o,
  input logic        cle_o,
  input logic        ale_o,
  input logic        we_no,
  input logic        re_no,
  input logic        rx_valid_o,
  input logic [12:0] status_o,
  input logic        irq_o
);
  logic [7:0] we_lo_q, re_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_q <= '0;
      re_lo_q <= '0;
    end else begin
      we_lo_q <= we_no ? 8'd0 : we_lo_q + 8'd1;
      re_lo_q <= re_no ? 8'd0 : re_lo_q + 8'd1;
    end
  end

  assert_latch_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  assert_we_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_no && !$past(we_no)) |-> (we_lo_q == 8'(T_LOW)));
  assert_re_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_no && !$past(re_no)) |-> (re_lo_q == 8'(T_LOW)));
  assert_rx_after_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (re_no && !$past(re_no)));
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_ready_o |-> (we_no && re_no && !cle_o && !ale_o));
  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != '0));
endmodule

bind nand_cycle_seq nseq_checker #(.T_LOW(T_LOW)) i_nseq_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .entry_ready_o (entry_ready_o),
  .cle_o         (cle_o),
  .ale_o         (ale_o),
  .we_no         (we_no),
  .re_no         (re_no),
  .rx_valid_o    (rx_valid_o),
  .status_o      (status_o),
  .irq_o         (irq_o)
);

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
  localparam int T_LOW  = 2;
  localparam int T_HIGH = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        entry_valid_i = 1'b0;
  logic [31:0] entry_data_i = '0;
  logic        entry_ready_o;
  logic [12:0] dma_count_i = '0;
  logic        tx_valid_i = 1'b1;
  logic [7:0]  tx_data_i;
  logic        tx_ready_o;
  logic        rx_valid_o;
  logic [7:0]  rx_data_o;
  logic        clr_valid_i = 1'b0;
  logic [12:0] clr_mask_i = '0;
  logic [12:0] status_o;
  logic        irq_o, cle_o, ale_o, we_no, re_no, io_oe_o;
  logic [7:0]  io_o, io_i;
  logic        rb_i = 1'b1;

  always #5 clk = ~clk;

  nand_cycle_seq #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) i_nand_cycle_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .entry_valid_i(entry_valid_i), .entry_data_i(entry_data_i), .entry_ready_o(entry_ready_o),
    .dma_count_i(dma_count_i),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .clr_valid_i(clr_valid_i), .clr_mask_i(clr_mask_i),
    .status_o(status_o), .irq_o(irq_o),
    .cle_o(cle_o), .ale_o(ale_o), .we_no(we_no), .re_no(re_no),
    .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i), .rb_i(rb_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device and DMA models
  logic [7:0] wr_data [256];
  logic [7:0] rd_data [256];
  int tx_ptr = 0, rd_ptr = 0;
  assign tx_data_i = wr_data[tx_ptr % 256];
  assign io_i      = rd_data[rd_ptr % 256];
  always @(posedge clk) if (tx_valid_i && tx_ready_o) tx_ptr <= tx_ptr + 1;

  // pulse recorder
  logic [7:0] rec_byte [1024];
  logic       rec_cle [1024], rec_ale [1024], rec_re [1024], rec_oe [1024];
  logic [7:0] rx_log [1024];
  int rec_cnt = 0, rx_cnt = 0, lo_we = 0, lo_re = 0, hi_cnt = 100;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic cap_cle, cap_ale, cap_oe;
  logic [7:0] cap_io;

  always @(negedge clk) begin
    if (!we_no) begin
      lo_we++; cap_cle = cle_o; cap_ale = ale_o; cap_io = io_o; cap_oe = io_oe_o;
    end
    if (!re_no) begin
      lo_re++; cap_cle = cle_o; cap_ale = ale_o; cap_oe = io_oe_o;
    end
    if ((!we_no && prev_we) || (!re_no && prev_re))
      check("R4 high time", 32'(hi_cnt >= T_HIGH), 1);
    if (we_no && re_no) hi_cnt++; else hi_cnt = 0;
    if (we_no && !prev_we) begin
      check("R4 low time", lo_we, T_LOW);
      rec_byte[rec_cnt % 1024] = cap_io; rec_cle[rec_cnt % 1024] = cap_cle;
      rec_ale[rec_cnt % 1024] = cap_ale; rec_re[rec_cnt % 1024] = 1'b0;
      rec_oe[rec_cnt % 1024] = cap_oe;
      rec_cnt++; lo_we = 0;
    end
    if (re_no && !prev_re) begin
      check("R4 low time", lo_re, T_LOW);
      rec_byte[rec_cnt % 1024] = 8'h00; rec_cle[rec_cnt % 1024] = cap_cle;
      rec_ale[rec_cnt % 1024] = cap_ale; rec_re[rec_cnt % 1024] = 1'b1;
      rec_oe[rec_cnt % 1024] = cap_oe;
      rec_cnt++; lo_re = 0; rd_ptr++;
    end
    if (rx_valid_o) begin
      rx_log[rx_cnt % 1024] = rx_data_o;
      rx_cnt++;
    end
    prev_we = we_no; prev_re = re_no;
  end

  task automatic clear(logic [12:0] m);
    @(negedge clk); clr_valid_i = 1'b1; clr_mask_i = m;
    @(negedge clk); clr_valid_i = 1'b0; clr_mask_i = '0;
  endtask

  task automatic issue(logic [31:0] w, logic [12:0] dcnt);
    @(negedge clk); entry_valid_i = 1'b1; entry_data_i = w; dma_count_i = dcnt;
    @(negedge clk); entry_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (!entry_ready_o) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int typ, bit wt, bit last, bit irq, int low);
    return (32'(wt) << 19) | (32'(last) << 18) | (32'(typ) << 16) | (32'(irq) << 13) | 32'(low & 12'hfff);
  endfunction

  // run one word and compare everything observable
  task automatic run(int typ, bit last, bit irq, int n, bit bad, logic [7:0] op, string tag);
    int r0, x0, t0, d0, np;
    logic [12:0] exp_st;
    clear('1);
    r0 = rec_cnt; x0 = rx_cnt; t0 = tx_ptr; d0 = rd_ptr;
    issue(mk(typ, 1'b0, last, irq, (typ >= 2) ? n - 1 : int'(op)),
          13'(bad ? n + 1 : n));
    wait_idle();
    repeat (2) @(negedge clk);
    np = bad ? 0 : ((typ >= 2) ? n : 1);
    check(bad ? "R8 no strobes" : "R1 pulse count", rec_cnt - r0, np);
    if (rec_cnt - r0 == np) begin
      for (int i = 0; i < np; i++) begin
        int k;
        k = (r0 + i) % 1024;
        if (typ == 1 || typ == 0) begin
          check("R1 cle", rec_cle[k], typ == 1);
          check("R1 ale", rec_ale[k], typ == 0);
          check("R1 byte", rec_byte[k], op);
          check("R1 drive", rec_oe[k], 1);
        end else if (typ == 2) begin
          check("R2 byte", rec_byte[k], wr_data[(t0 + i) % 256]);
          check("R2 latches low", {rec_cle[k], rec_ale[k], rec_re[k]}, 0);
        end else begin
          check("R3 strobe kind", {rec_cle[k], rec_ale[k], rec_re[k]}, 1);
        end
      end
    end
    if (typ == 3 && !bad) begin
      check("R3 rx count", rx_cnt - x0, n);
      for (int i = 0; i < n && i < rx_cnt - x0; i++)
        check("R3 rx byte", rx_log[(x0 + i) % 1024], rd_data[(d0 + i) % 256]);
    end else check("R3 no rx", rx_cnt - x0, 0);
    exp_st = '0;
    if (bad) exp_st[11] = 1'b1;
    else begin
      exp_st[9] = last;
      exp_st[6] = (typ == 2);
      exp_st[7] = (typ == 3);
    end
    check({tag, " status R6 R7 R8"}, status_o, exp_st);
    check("R10 irq", irq_o, irq && (exp_st != 0));
  endtask

  initial begin
    int t_start;
    void'($urandom(32'h1234_5a5a));
    for (int i = 0; i < 256; i++) begin
      wr_data[i] = 8'($urandom);
      rd_data[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 status", status_o, 0);
    check("R11 irq", irq_o, 0);
    check("R11 pins", {we_no, re_no, cle_o, ale_o}, 4'b1100);
    check("R11 ready", entry_ready_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    run(1, 1, 1, 1, 0, 8'h70, "cmd");
    run(0, 0, 1, 1, 0, 8'h3c, "addr no-last");
    run(2, 1, 0, 16, 0, 8'h00, "write16");
    run(3, 1, 1, 5, 0, 8'h00, "read5");
    run(2, 0, 1, 1, 0, 8'h00, "write1");
    run(3, 0, 1, 4, 1, 8'h00, "bad len");
    run(2, 1, 0, 3, 1, 8'h00, "bad len no irq");

    // R9 partial clear: bits 6 and 9 armed
    clear('1);
    issue(mk(2, 1'b0, 1'b1, 1'b1, 1), 13'd2);
    wait_idle();
    check("R9 before", status_o, 13'h240);
    clear(13'h200);
    check("R9 partial", status_o, 13'h040);
    check("R10 still", irq_o, 1);
    clear(13'h040);
    check("R9 all", status_o, 0);
    check("R10 cleared", irq_o, 0);

    // R5 wait for ready, R12 busy
    clear('1);
    rb_i = 1'b0;
    t_start = 0;
    issue(mk(1, 1'b1, 1'b1, 1'b0, 8'h10), 13'd0);
    issue(mk(1, 1'b0, 1'b1, 1'b0, 8'hee), 13'd0);  // offered while busy: must not be taken
    entry_valid_i = 1'b1;
    repeat (25) @(negedge clk);
    check("R5 not done while busy", status_o[9], 0);
    check("R12 not ready while busy", entry_ready_o, 0);
    entry_valid_i = 1'b0;
    check("R12 one pulse only", rec_cnt > 0 ? 32'(rec_byte[(rec_cnt - 1) % 1024]) : 0, 8'h10);
    rb_i = 1'b1;
    wait_idle();
    @(negedge clk);
    check("R5 done after ready", status_o[9], 1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int typ, n;
      bit last, irq, bad;
      typ  = $urandom_range(0, 3);
      last = 1'($urandom_range(0, 1));
      irq  = 1'($urandom_range(0, 1));
      n    = (typ >= 2) ? $urandom_range(1, 16) : 1;
      bad  = (typ >= 2) && ($urandom_range(0, 5) == 0);
      run(typ, last, irq, n, bad, 8'($urandom), "rand");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule